// File: doc/BRIEF.md
# Ternary Match Table with Lowest-Index Priority

This block is a small ternary lookup table. Every row holds a data word, a per-bit don't-care mask and a valid flag. A shared key register and a shared exclusion mask sit beside the rows. A single operation port accepts one command per clock. A command can store a row, retire a row, set the key, set the exclusion mask, or launch a lookup. A lookup compares the key against all rows at once. Two cycles later it reports a hit flag and the smallest matching row number, together with a result strobe. Lookups can be issued on every clock, and their results come back in the order they were issued.

The exclusion mask lets one physical row carry several logical fields. Setting the bits of the fields that are not of interest removes them from every comparison. A separate output always names the lowest-numbered empty row, and a full flag shows when no row is empty. Software can use these to place new rows without a scan. The pipeline has two named stages. The capture stage freezes the match vector of the lookup. The resolve stage reduces that vector to a row number.

Top module: `tcam_search`

## Requirements
- R1: After reset no row is valid, `res_valid` is 0, `free_index` is 0 and `free_full` is 0. The key and the exclusion mask are all zeros.
- R2: Opcode 1 (store) writes `op_data` and `op_mask` into row `op_addr` and marks the row valid. Opcode 2 (retire) clears the valid flag of row `op_addr`. A row that is not valid never matches.
- R3: In a row's mask a 1 makes that bit position don't-care for that row.
- R4: Opcode 4 loads `op_data` into the exclusion mask. A 1 in it removes that bit position from the comparison for every row, combined by OR with each row's own mask. Opcode 3 loads `op_data` into the key.
- R5: When several valid rows match, `res_index` is the lowest matching row number.
- R6: `free_index` always shows the lowest row whose valid flag is clear. When every row is valid, `free_full` is 1 and `free_index` is 0.
- R7: A lookup (opcode 5) issued before clock edge k gives `res_valid` high after edge k+1, for one cycle per lookup. Back-to-back lookups produce results on consecutive cycles in issue order. `res_valid` is low otherwise, and opcode 0 does nothing.
- R8: When a lookup finds no match, `res_hit` is 0 and `res_index` is 0.
- R9: A lookup uses the table and key as they stand when it is issued. A store or retire issued in the next cycle does not change that lookup's result, but it does affect later lookups. A key loaded in the cycle before a lookup is used by that lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 3 | Operation: 0 idle, 1 store, 2 retire, 3 key, 4 exclusion mask, 5 lookup |
| op_addr | input | AW | Row number for store and retire |
| op_data | input | WIDTH | Row data, key or exclusion mask value |
| op_mask | input | WIDTH | Row don't-care mask for store |
| res_valid | output | 1 | Lookup result strobe |
| res_hit | output | 1 | At least one row matched |
| res_index | output | AW | Lowest matching row number, 0 on miss |
| free_index | output | AW | Lowest empty row number |
| free_full | output | 1 | No empty row remains |

## Verification
Two rows are given the same exact data, so that a lookup must pick the lower one. Rows with local don't-care bits and a non-zero exclusion mask show whether masking is applied per row or globally. A key that matches nothing, and a row that was retired, show that invalid rows and misses are handled apart from hits. Lookups issued back to back, a store right after a lookup, and a key loaded just before a lookup separate the correct capture timing from an off-by-one pipeline. Filling the table and then a long mixed random command stream test the full flag and the priority choice across many table contents.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_WRITE  = 3'd1,
        OP_INVAL  = 3'd2,
        OP_LDKEY  = 3'd3,
        OP_LDGM   = 3'd4,
        OP_SEARCH = 3'd5
    } tcam_op_e;
endpackage

// File: rtl/tcam_first_set.sv
module tcam_first_set #(
    parameter int N  = 16,
    parameter int AW = 4
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [AW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = AW'(i);
            end
        end
    end

    logic [N-1:0] below;
    always_comb begin
        below = ({{(N-1){1'b0}}, 1'b1} << idx) - 1'b1;
        if (found) begin
            assert_pick_is_set_R5: assert (vec[idx]);
            assert_pick_is_lowest_R5: assert ((vec & below) == '0);
        end else begin
            assert_none_means_empty_R8: assert (vec == '0);
        end
    end
endmodule

// File: rtl/tcam_store.sv
module tcam_store
    import tcam_pkg::*;
#(
    parameter int N  = 16,
    parameter int W  = 32,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tcam_op_e      op,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  data,
    input  logic [W-1:0]  mask,
    output logic [N-1:0]  match_vec,
    output logic [N-1:0]  valid_vec
);
    logic [W-1:0] row_data [N];
    logic [W-1:0] row_mask [N];
    logic [N-1:0] valid_q;
    logic [W-1:0] key_q;
    logic [W-1:0] gmask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            key_q   <= '0;
            gmask_q <= '0;
            for (int i = 0; i < N; i++) begin
                row_data[i] <= '0;
                row_mask[i] <= '0;
            end
        end else begin
            unique case (op)
                OP_WRITE: begin
                    row_data[addr] <= data;
                    row_mask[addr] <= mask;
                    valid_q[addr]  <= 1'b1;
                end
                OP_INVAL:  valid_q[addr] <= 1'b0;
                OP_LDKEY:  key_q   <= data;
                OP_LDGM:   gmask_q <= data;
                OP_SEARCH: ;
                default:   ;
            endcase
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_row
        assign match_vec[g] = valid_q[g] &&
            (((row_data[g] ^ key_q) & ~(row_mask[g] | gmask_q)) == '0);
    end

    assign valid_vec = valid_q;

    assert_store_sets_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE) |=> valid_q[$past(addr)]);
    assert_retire_clears_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INVAL) |=> !valid_q[$past(addr)]);
endmodule

// File: rtl/tcam_search.sv
module tcam_search
    import tcam_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int WIDTH   = 32,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_code,
    input  logic [AW-1:0]    op_addr,
    input  logic [WIDTH-1:0] op_data,
    input  logic [WIDTH-1:0] op_mask,
    output logic             res_valid,
    output logic             res_hit,
    output logic [AW-1:0]    res_index,
    output logic [AW-1:0]    free_index,
    output logic             free_full
);
    tcam_op_e op;
    assign op = tcam_op_e'(op_code);

    logic [ENTRIES-1:0] match_vec;
    logic [ENTRIES-1:0] valid_vec;

    tcam_store #(.N(ENTRIES), .W(WIDTH), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .op(op), .addr(op_addr),
        .data(op_data), .mask(op_mask),
        .match_vec(match_vec), .valid_vec(valid_vec)
    );

    // capture stage
    logic               cap_v;
    logic [ENTRIES-1:0] cap_match;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_v     <= 1'b0;
            cap_match <= '0;
        end else begin
            cap_v     <= (op == OP_SEARCH);
            cap_match <= (op == OP_SEARCH) ? match_vec : '0;
        end
    end

    // resolve stage
    logic          m_found;
    logic [AW-1:0] m_idx;
    tcam_first_set #(.N(ENTRIES), .AW(AW)) u_match_pick (
        .vec(cap_match), .found(m_found), .idx(m_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_index <= '0;
        end else begin
            res_valid <= cap_v;
            res_hit   <= cap_v && m_found;
            res_index <= (cap_v && m_found) ? m_idx : '0;
        end
    end

    // next free row
    logic          f_found;
    logic [AW-1:0] f_idx;
    tcam_first_set #(.N(ENTRIES), .AW(AW)) u_free_pick (
        .vec(~valid_vec), .found(f_found), .idx(f_idx)
    );
    assign free_full  = !f_found;
    assign free_index = f_idx;

    assert_result_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SEARCH) |=> ##1 res_valid);
    assert_no_stray_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(op_code == 3'd5, 2));
    assert_idle_no_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !res_hit);
    assert_miss_index_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_index == '0));
    assert_full_index_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        free_full |-> (free_index == '0));
    assert_full_when_all_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (&valid_vec) |-> free_full);
endmodule

// File: tb/tcam_search_bench.sv
module tcam_search_bench;
    localparam int PERIOD = 10;
    localparam int N  = 16;
    localparam int W  = 32;
    localparam int AW = 4;

    logic          clk;
    logic          rst_n;
    logic [2:0]    op_code;
    logic [AW-1:0] op_addr;
    logic [W-1:0]  op_data;
    logic [W-1:0]  op_mask;
    logic          res_valid;
    logic          res_hit;
    logic [AW-1:0] res_index;
    logic [AW-1:0] free_index;
    logic          free_full;

    tcam_search #(.ENTRIES(N), .WIDTH(W)) u_tcam_search (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_addr(op_addr),
        .op_data(op_data), .op_mask(op_mask), .res_valid(res_valid),
        .res_hit(res_hit), .res_index(res_index), .free_index(free_index),
        .free_full(free_full)
    );

    initial clk = 1'b0;
    always #(PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    string cur_req = "R7";

    // reference model
    logic [W-1:0] m_data [N];
    logic [W-1:0] m_mask [N];
    bit           m_val  [N];
    logic [W-1:0] m_key;
    logic [W-1:0] m_gm;
    bit e1_v, e1_h, e2_v, e2_h;
    int e1_i, e2_i;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_data[i] = '0; m_mask[i] = '0; m_val[i] = 0;
        end
        m_key = '0; m_gm = '0;
        e1_v = 0; e1_h = 0; e1_i = 0; e2_v = 0; e2_h = 0; e2_i = 0;
    endtask

    task automatic compare_outputs();
        int fi;
        bit full;
        chk(cur_req, "res_valid", int'(res_valid), int'(e2_v));
        if (e2_v) begin
            chk(cur_req, "res_hit", int'(res_hit), int'(e2_h));
            chk(cur_req, "res_index", int'(res_index), e2_i);
        end
        full = 1; fi = 0;
        for (int i = N - 1; i >= 0; i--) if (!m_val[i]) begin full = 0; fi = i; end
        chk("R6", "free_full", int'(free_full), int'(full));
        chk("R6", "free_index", int'(free_index), fi);
    endtask

    task automatic cyc(logic [2:0] op, int addr, logic [W-1:0] d, logic [W-1:0] mk);
        bit nv, nh;
        int ni;
        @(negedge clk);
        compare_outputs();
        op_code = op; op_addr = AW'(addr); op_data = d; op_mask = mk;
        nv = 0; nh = 0; ni = 0;
        if (op == 3'd5) begin
            nv = 1;
            for (int i = N - 1; i >= 0; i--) begin
                bit ok;
                ok = m_val[i];
                for (int b = 0; b < W; b++)
                    if (!m_mask[i][b] && !m_gm[b] && (m_data[i][b] != m_key[b])) ok = 0;
                if (ok) begin nh = 1; ni = i; end
            end
        end
        case (op)
            3'd1: begin m_data[addr] = d; m_mask[addr] = mk; m_val[addr] = 1; end
            3'd2: m_val[addr] = 0;
            3'd3: m_key = d;
            3'd4: m_gm = d;
            default: ;
        endcase
        @(posedge clk);
        e2_v = e1_v; e2_h = e1_h; e2_i = e1_i;
        e1_v = nv; e1_h = nh; e1_i = ni;
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        rst_n = 0; op_code = 3'd0; op_addr = '0; op_data = '0; op_mask = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1", "res_valid", int'(res_valid), 0);
        chk("R1", "free_index", int'(free_index), 0);
        chk("R1", "free_full", int'(free_full), 0);

        // R5 two rows with identical exact data
        cur_req = "R5";
        cyc(3'd1, 5, 32'hA5A5_0001, '0);
        cyc(3'd1, 3, 32'hA5A5_0001, '0);
        cyc(3'd3, 0, 32'hA5A5_0001, '0);
        cyc(3'd5, 0, '0, '0);

        // R7 back-to-back lookups with differing keys
        cur_req = "R7";
        cyc(3'd5, 0, '0, '0);
        cyc(3'd3, 0, 32'h0BAD_0000, '0);
        cyc(3'd5, 0, '0, '0);
        cyc(3'd3, 0, 32'hA5A5_0001, '0);
        cyc(3'd5, 0, '0, '0);
        cyc(3'd5, 0, '0, '0);
        cyc(3'd0, 9, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

        // R3 row-local don't-care bits
        cur_req = "R3";
        cyc(3'd1, 1, 32'h1234_5600, 32'h0000_00FF);
        cyc(3'd3, 0, 32'h1234_56AB, '0);
        cyc(3'd5, 0, '0, '0);
        cyc(3'd3, 0, 32'h1234_57AB, '0);
        cyc(3'd5, 0, '0, '0);

        // R4 global exclusion mask
        cur_req = "R4";
        cyc(3'd1, 7, 32'hAAAA_0000, '0);
        cyc(3'd3, 0, 32'hAAAA_5555, '0);
        cyc(3'd5, 0, '0, '0);
        cyc(3'd4, 0, 32'h0000_FFFF, '0);
        cyc(3'd5, 0, '0, '0);
        cyc(3'd4, 0, '0, '0);

        // R8 miss
        cur_req = "R8";
        cyc(3'd3, 0, 32'hDEAD_BEEF, '0);
        cyc(3'd5, 0, '0, '0);

        // R2 retired row no longer matches
        cur_req = "R2";
        cyc(3'd3, 0, 32'hA5A5_0001, '0);
        cyc(3'd2, 3, '0, '0);
        cyc(3'd5, 0, '0, '0);
        cyc(3'd2, 5, '0, '0);
        cyc(3'd5, 0, '0, '0);

        // R9 store right after a lookup, key right before a lookup
        cur_req = "R9";
        cyc(3'd5, 0, '0, '0);
        cyc(3'd1, 0, 32'hA5A5_0001, '0);
        cyc(3'd5, 0, '0, '0);
        cyc(3'd3, 0, 32'hAAAA_0000, '0);
        cyc(3'd5, 0, '0, '0);
        cyc(3'd2, 7, '0, '0);
        cyc(3'd5, 0, '0, '0);

        // R6 fill the table
        cur_req = "R6";
        for (int i = 0; i < N; i++) cyc(3'd1, i, 32'h0000_1000 + W'(i), '0);
        cyc(3'd4, 0, 32'hFFFF_FFFF, '0);
        cyc(3'd5, 0, '0, '0);
        cyc(3'd4, 0, '0, '0);
        cyc(3'd2, 9, '0, '0);
        cyc(3'd2, 12, '0, '0);
        cyc(3'd3, 0, 32'h0000_100C, '0);
        cyc(3'd5, 0, '0, '0);

        // R5 mixed random stream with a small value domain
        cur_req = "R5";
        for (int k = 0; k < 400; k++) begin
            int op;
            logic [W-1:0] d, mk;
            op = $urandom_range(0, 5);
            if (op == 4) d = ($urandom_range(0, 2) == 0) ? 32'h0000_000F : '0;
            else d = W'($urandom_range(0, 3)) << 4 | W'($urandom_range(0, 3));
            mk = ($urandom_range(0, 2) == 0) ? 32'h0000_00F0 : '0;
            if ($urandom_range(0, 2) == 0) op = 5;
            cyc(3'(op), $urandom_range(0, N - 1), d, mk);
        end

        cur_req = "R7";
        repeat (4) cyc(3'd0, 0, '0, '0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule